// File: doc/BRIEF.md
# Coherent Sensor Readout Bank

This block is the read side of a hardware-monitor register file. It keeps the latest 10-bit result for eight measurement channels and serves them on a byte-wide read port. Channels 0 to 4 are supply voltages and channels 5 to 7 are temperatures. Each channel has its own byte at addresses 0x20 to 0x27, and that byte gives the upper 8 bits of the result. The 2 low bits of every channel are packed into two shared low-bits bytes at 0x76 and 0x77.

Results arrive on a plain sample interface: one strobe per channel, with the 10-bit values side by side in one flat bus. Software reads the low-bits byte first and then the upper bytes. The low-bits read freezes every channel whose bits it carries. A frozen channel ignores new results until its upper byte has been read, so the 10-bit value that software rebuilds always comes from one sample.

A temperature upper byte equal to 0x80 is the sensor-fault code. That code is also the reset value of the temperature channels. A per-channel fault flag follows it directly.

Top module: `sensor_snapshot_bank`

## Requirements
- R1: After reset, channels 0 to 4 read 0x00 at 0x20 to 0x24, and channels 5 to 7 read 0x80 at 0x25 to 0x27. Both low-bits bytes read 0x00 and no channel is frozen.
- R2: Read timing. A read with `rd_en` high at address 0x20+i puts bits [9:2] of channel i on `rd_data` after the next rising edge.
- R3: Low-bits packing. The low 2 bits of channel i sit at bit 2*(i mod 4) of the byte at 0x76 + i/4. Bits not assigned to any channel read 0.
- R4: An unfrozen channel stores the value on its strobed slice at the clock edge where its strobe is high. A read in the following cycle returns that value.
- R5: A read at 0x76+j freezes every channel whose low bits live in that byte. A strobe for one of those channels on the same edge as that read is dropped.
- R6: A frozen channel drops every strobed value. Its upper byte returns the value held at freeze time, and that read unfreezes the channel. A strobe on the next edge is stored.
- R7: Reading an upper byte while the channel is not frozen returns the live value and freezes nothing.
- R8: A read at any address other than 0x20 to 0x27, 0x76 or 0x77 returns 0x00 and changes no freeze state.
- R9: `temp_fault[t]` is high exactly when the upper byte of channel 5+t equals 0x80.
- R10: Reading a low-bits byte again while its channels stay frozen returns the same value as the first read.
- R11: `rd_data` changes only on the edge after a cycle with `rd_en` high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 8 | New-result strobe, one per channel |
| smp_data | input | 80 | Results; channel i occupies bits [10i+9:10i] |
| rd_en | input | 1 | Read request for this cycle |
| rd_addr | input | 8 | Register address of the read |
| rd_data | output | 8 | Read result, registered |
| temp_fault | output | 3 | Fault code present on temperature channel t |

## Verification
The assertions assume the following about the inputs:
- Inputs are stable around each rising edge.
- A read names only one address per cycle.
- Strobes may arrive on any cycle, including the cycle of a read that freezes or releases the same channel.

Under those assumptions, each assertion relates a decoded read event to the freeze flags and the held values one edge later. The stimulus changes every input at the falling edge. It deliberately lines up strobes with low-bits reads and with upper-byte reads of frozen channels, and it mixes in addresses just outside the mapped ranges.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int SMP_W  = 10;
  localparam int MSB_W  = 8;
  localparam int LSB_W  = SMP_W - MSB_W;
  localparam int ADDR_W = 8;

  typedef logic [SMP_W-1:0] sample_t;
  typedef logic [MSB_W-1:0] byte_t;

  localparam byte_t FAULT_CODE = 8'h80;

  function automatic byte_t msb_of(sample_t s);
    return s[SMP_W-1:LSB_W];
  endfunction

  function automatic logic [LSB_W-1:0] lsb_of(sample_t s);
    return s[LSB_W-1:0];
  endfunction

  // which low-bits byte carries channel ch
  function automatic int ext_slot(int ch);
    return (ch * LSB_W) / MSB_W;
  endfunction

  function automatic int ext_count(int n_ch);
    return (n_ch * LSB_W + MSB_W - 1) / MSB_W;
  endfunction

  function automatic sample_t temp_reset();
    return {FAULT_CODE, {LSB_W{1'b0}}};
  endfunction
endpackage

// File: rtl/ssb_addr_decode.sv
module ssb_addr_decode
  import ssb_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int N_EXT = 2,
  parameter logic [ADDR_W-1:0] MSB_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] EXT_BASE = 8'h76
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [N_CH-1:0]   msb_hit,
  output logic [N_EXT-1:0]  ext_hit,
  output logic              unmapped
);
  for (genvar i = 0; i < N_CH; i++) begin : g_msb
    assign msb_hit[i] = rd_en && (rd_addr == ADDR_W'(MSB_BASE + i));
  end

  for (genvar j = 0; j < N_EXT; j++) begin : g_ext
    assign ext_hit[j] = rd_en && (rd_addr == ADDR_W'(EXT_BASE + j));
  end

  assign unmapped = rd_en && !(|msb_hit) && !(|ext_hit);
endmodule

// File: rtl/ssb_channel.sv
module ssb_channel
  import ssb_pkg::*;
#(
  parameter sample_t RST_VAL = '0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    smp_valid,
  input  sample_t smp_data,
  input  logic    freeze_req,
  input  logic    release_req,
  output sample_t held,
  output logic    frozen
);
  logic take;

  // a strobe is dropped while frozen or on the edge that freezes
  assign take = smp_valid && !frozen && !freeze_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= RST_VAL;
      frozen <= 1'b0;
    end else begin
      if (take) held <= smp_data;
      if (freeze_req)       frozen <= 1'b1;
      else if (release_req) frozen <= 1'b0;
    end
  end
endmodule

// File: rtl/ssb_read_mux.sv
module ssb_read_mux
  import ssb_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int N_EXT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [N_CH*SMP_W-1:0] held_flat,
  input  logic [N_CH-1:0]       msb_hit,
  input  logic [N_EXT-1:0]      ext_hit,
  output byte_t                 rd_data
);
  logic [N_EXT*MSB_W-1:0] ext_flat;
  byte_t                  nxt;

  always_comb begin
    ext_flat = '0;
    for (int ch = 0; ch < N_CH; ch++)
      ext_flat[ch*LSB_W +: LSB_W] = lsb_of(held_flat[ch*SMP_W +: SMP_W]);
  end

  always_comb begin
    nxt = '0;
    for (int ch = 0; ch < N_CH; ch++)
      if (msb_hit[ch]) nxt = nxt | msb_of(held_flat[ch*SMP_W +: SMP_W]);
    for (int j = 0; j < N_EXT; j++)
      if (ext_hit[j]) nxt = nxt | ext_flat[j*MSB_W +: MSB_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= nxt;
  end
endmodule

// File: rtl/sensor_snapshot_bank.sv
module sensor_snapshot_bank
  import ssb_pkg::*;
#(
  parameter int N_VOLT = 5,
  parameter int N_TEMP = 3,
  parameter logic [ADDR_W-1:0] MSB_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] EXT_BASE = 8'h76
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_VOLT+N_TEMP-1:0]       smp_valid,
  input  logic [(N_VOLT+N_TEMP)*10-1:0]  smp_data,
  input  logic                           rd_en,
  input  logic [7:0]                     rd_addr,
  output logic [7:0]                     rd_data,
  output logic [N_TEMP-1:0]              temp_fault
);
  localparam int N_CH  = N_VOLT + N_TEMP;
  localparam int N_EXT = ext_count(N_CH);

  // named internal events, visible to the bound checker
  logic [N_CH-1:0]       msb_hit;
  logic [N_EXT-1:0]      ext_hit;
  logic                  unmapped;
  logic [N_CH-1:0]       frozen;
  logic [N_CH*SMP_W-1:0] held_flat;

  ssb_addr_decode #(
    .N_CH(N_CH), .N_EXT(N_EXT), .MSB_BASE(MSB_BASE), .EXT_BASE(EXT_BASE)
  ) u_dec (
    .rd_en(rd_en), .rd_addr(rd_addr),
    .msb_hit(msb_hit), .ext_hit(ext_hit), .unmapped(unmapped)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int      GRP = ext_slot(i);
    localparam sample_t RV  = (i >= N_VOLT) ? temp_reset() : '0;
    ssb_channel #(.RST_VAL(RV)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .smp_valid(smp_valid[i]),
      .smp_data(smp_data[i*SMP_W +: SMP_W]),
      .freeze_req(ext_hit[GRP]),
      .release_req(msb_hit[i]),
      .held(held_flat[i*SMP_W +: SMP_W]),
      .frozen(frozen[i])
    );
  end

  ssb_read_mux #(.N_CH(N_CH), .N_EXT(N_EXT)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
    .held_flat(held_flat), .msb_hit(msb_hit), .ext_hit(ext_hit),
    .rd_data(rd_data)
  );

  for (genvar t = 0; t < N_TEMP; t++) begin : g_flt
    assign temp_fault[t] =
      (msb_of(held_flat[(N_VOLT+t)*SMP_W +: SMP_W]) == FAULT_CODE);
  end
endmodule

// File: rtl/ssb_bank_chk.sv
module ssb_bank_chk
  import ssb_pkg::*;
#(
  parameter int N_VOLT = 5,
  parameter int N_TEMP = 3,
  parameter logic [ADDR_W-1:0] MSB_BASE = 8'h20
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [N_VOLT+N_TEMP-1:0]              smp_valid,
  input logic [(N_VOLT+N_TEMP)*SMP_W-1:0]      smp_data,
  input logic                                  rd_en,
  input logic [7:0]                            rd_data,
  input logic [7:0]                            rd_addr,
  input logic [N_TEMP-1:0]                     temp_fault,
  input logic [N_VOLT+N_TEMP-1:0]              msb_hit,
  input logic [ext_count(N_VOLT+N_TEMP)-1:0]   ext_hit,
  input logic                                  unmapped,
  input logic [N_VOLT+N_TEMP-1:0]              frozen,
  input logic [(N_VOLT+N_TEMP)*SMP_W-1:0]      held_flat
);
  localparam int N_CH = N_VOLT + N_TEMP;

  for (genvar i = 0; i < N_CH; i++) begin : g_c
    localparam int GRP = ext_slot(i);

    // R4
    live_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid[i] && !frozen[i] && !ext_hit[GRP]
      |=> held_flat[i*SMP_W +: SMP_W] == $past(smp_data[i*SMP_W +: SMP_W]));

    // R5
    ext_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_hit[GRP] |=> frozen[i]);

    // R6
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frozen[i] |=> $stable(held_flat[i*SMP_W +: SMP_W]));

    // R6
    msb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msb_hit[i] |=> !frozen[i]);
  end

  for (genvar t = 0; t < N_TEMP; t++) begin : g_t
    // R9
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_addr == ADDR_W'(MSB_BASE + N_VOLT + t)
      |=> (rd_data == FAULT_CODE) == $past(temp_fault[t]));
  end

  // R7
  no_spurious_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ext_hit) |=> ((frozen & ~$past(frozen)) == '0));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> rd_data == 8'h00 && $stable(frozen));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind sensor_snapshot_bank ssb_bank_chk #(
  .N_VOLT(N_VOLT), .N_TEMP(N_TEMP), .MSB_BASE(MSB_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .rd_en(rd_en), .rd_data(rd_data), .rd_addr(rd_addr),
  .temp_fault(temp_fault), .msb_hit(msb_hit), .ext_hit(ext_hit),
  .unmapped(unmapped), .frozen(frozen), .held_flat(held_flat)
);

// File: tb/sensor_snapshot_bank_tb_top.sv
`timescale 1ns/1ps
module sensor_snapshot_bank_tb_top;
  localparam int NV = 5;
  localparam int NT = 3;
  localparam int NC = NV + NT;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [NC-1:0]   smp_valid;
  logic [NC*10-1:0] smp_data;
  logic            rd_en;
  logic [7:0]      rd_addr;
  wire  [7:0]      rd_data;
  wire  [NT-1:0]   temp_fault;
  logic [9:0]      sd [NC];

  always_comb
    for (int i = 0; i < NC; i++) smp_data[i*10 +: 10] = sd[i];

  sensor_snapshot_bank dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .temp_fault(temp_fault)
  );

  int errors = 0;
  int checks = 0;
  bit live   = 0;

  // behavioural reference
  int mval [NC];
  bit mfrz [NC];
  int mrd;

  function automatic int ext_byte(int j);
    int b = 0;
    for (int ch = 0; ch < NC; ch++) begin
      int pos = ch * 2 - j * 8;
      if (pos >= 0 && pos < 8) b = b | ((mval[ch] % 4) << pos);
    end
    return b;
  endfunction

  function automatic int fault_exp();
    int f = 0;
    for (int t = 0; t < NT; t++)
      if ((mval[NV+t] >> 2) == 128) f = f | (1 << t);
    return f;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        mval[i] = (i >= NV) ? 'h200 : 0;
        mfrz[i] = 0;
      end
      mrd = 0;
    end else begin
      if (rd_en) begin
        if (rd_addr >= 8'h20 && rd_addr < 8'h20 + NC) mrd = mval[rd_addr - 8'h20] >> 2;
        else if (rd_addr == 8'h76 || rd_addr == 8'h77) mrd = ext_byte(rd_addr - 8'h76);
        else mrd = 0;
      end
      for (int i = 0; i < NC; i++) begin
        bit er;
        er = rd_en && (rd_addr == 8'h76 + (i * 2) / 8);
        if (smp_valid[i] && !mfrz[i] && !er) mval[i] = smp_data[i*10 +: 10];
        if (er) mfrz[i] = 1;
        else if (rd_en && rd_addr == 8'h20 + i) mfrz[i] = 0;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (live) begin
      chk("R2 model rd_data", rd_data, mrd);
      chk("R9 model temp_fault", temp_fault, fault_exp());
    end
  endtask

  task automatic rd(int addr, int exp, string req);
    rd_en = 1; rd_addr = addr[7:0]; smp_valid = '0;
    step();
    chk(req, rd_data, exp);
    rd_en = 0;
  endtask

  task automatic smp1(int ch, int data);
    sd[ch] = data[9:0]; smp_valid = '0; smp_valid[ch] = 1'b1; rd_en = 0;
    step();
    smp_valid = '0;
  endtask

  initial begin
    #(8 * 200000);
    chk("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int held_v;
    int alist [14] = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26,
                       8'h27, 8'h76, 8'h77, 8'h00, 8'h75, 8'h78, 8'hFF};
    rst_n = 0; rd_en = 0; rd_addr = 0; smp_valid = '0;
    for (int i = 0; i < NC; i++) sd[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    step();

    // R1 reset values
    chk("R9 reset fault flags", temp_fault, 3'b111);
    rd(8'h76, 8'h00, "R1 low-bits 0x76");
    rd(8'h77, 8'h00, "R1 low-bits 0x77");
    for (int i = 0; i < NC; i++) rd(8'h20 + i, (i < NV) ? 8'h00 : 8'h80, "R1 upper byte");

    // R4/R7 live tracking
    sd[0] = 10'h2AB; sd[4] = 10'h3C5; sd[6] = 10'h1F3;
    smp_valid = 8'b0101_0001; step(); smp_valid = '0;
    chk("R9 fault after load", temp_fault, 3'b101);
    rd(8'h20, 8'hAA, "R4 live store");
    smp1(0, 10'h0FF);
    rd(8'h20, 8'h3F, "R7 no freeze on plain read");

    // R3/R10/R6 freeze cycle on group 0
    rd(8'h76, 8'h03, "R3 packing 0x76");
    sd[0] = 10'h155; sd[1] = 10'h3FF; smp_valid = 8'b0000_0011; step(); smp_valid = '0;
    rd(8'h76, 8'h03, "R10 repeat low-bits read");
    rd(8'h20, 8'h3F, "R6 frozen value");
    smp_valid = 8'b0000_0011; step(); smp_valid = '0;
    rd(8'h20, 8'h55, "R6 resumed after read");
    rd(8'h21, 8'h00, "R6 still dropped while frozen");
    rd(8'h22, 8'h00, "R6 release ch2");
    rd(8'h23, 8'h00, "R6 release ch3");

    // R5 same-edge strobe is dropped
    sd[7] = 10'h2C2;
    rd_en = 1; rd_addr = 8'h77; smp_valid = 8'b1000_0000;
    step(); rd_en = 0; smp_valid = '0;
    chk("R3 packing 0x77", rd_data, 8'h31);
    rd(8'h27, 8'h80, "R5 same-edge strobe dropped");

    // R8 unmapped reads
    rd(8'h75, 8'h00, "R8 unmapped 0x75");
    smp1(7, 10'h2C2);
    rd(8'h27, 8'hB0, "R8 no freeze from unmapped");
    rd(8'h00, 8'h00, "R8 unmapped 0x00");
    rd(8'hFF, 8'h00, "R8 unmapped 0xFF");
    rd(8'h78, 8'h00, "R8 unmapped 0x78");
    smp1(4, 10'h004);
    rd(8'h24, 8'hF1, "R8 freeze kept across unmapped");
    rd(8'h25, 8'h80, "R6 release ch5");
    rd(8'h26, 8'h7C, "R6 release ch6");

    // R11 hold when idle
    held_v = rd_data;
    rd_addr = 8'h21; step();
    chk("R11 rd_data held", rd_data, held_v);

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      rd_en = ($urandom % 2) == 1;
      rd_addr = alist[$urandom % 14][7:0];
      smp_valid = $urandom;
      for (int i = 0; i < NC; i++) sd[i] = $urandom;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule